// File: doc/BRIEF.md
# Indexed Float-Bits-to-Integer-Word Store Unit

This unit executes one store instruction. The instruction takes the low 32 bits of a 64-bit floating-point register and writes them to memory as a raw integer word. The bits are copied unchanged: there is no conversion, no rounding, and no look at the value. An issue stage hands over the 32-bit instruction word, the instruction's PC and the register-file read data: two integer operands and one floating-point operand. It also supplies the FP-enable bit of the machine state and the current load-reserve state. The unit decodes the word and forms the effective address from an optional base plus an index. It then writes the word in big-endian byte order through a byte-enabled, word-aligned memory write port.

Both the issue port and the memory port use valid/ready. A transfer happens in any cycle where valid and ready are both high. The unit accepts a new instruction only when idle, so `iss_ready` stays low while a store is outstanding. Once `mem_valid` rises, the address, data and byte enables stay fixed until `mem_ready` is seen. A store that crosses a word boundary is split into two beats, lower word first. The PC update and the reservation clear are combinational pulses in the cycle the final beat is accepted. A word that does not decode, and an FP-disabled store, each end in the issue cycle with a one-cycle flag.

Top module: `fpiw_store_unit`

## Requirements
- R1: The instruction matches when `iss_instr[31:26]` equals 31 and `iss_instr[10:1]` equals 983, so the zero-operand word is 0x7C0007AE. `iss_instr[0]` is ignored. The fields are: source FP register in `[25:21]`, base register in `[20:16]`, index register in `[15:11]`.
- R2: An accepted word that does not match pulses `illegal_insn` in its issue cycle. It produces no memory beat and no `pc_we`.
- R3: When the base field `iss_instr[20:16]` is 0, the base is zero and `iss_gpr_a` has no effect. Otherwise the base is `iss_gpr_a`.
- R4: The effective address EA is bits [31:0] of the 64-bit sum base + `iss_gpr_b`. Carries out of bit 31 are discarded.
- R5: The stored word is `iss_fpr[31:0]`, copied bit for bit. Lane j (`mem_be[3-j]`, `mem_data[31-8j -: 8]`) writes byte address `mem_addr`+j. The most significant byte of the word lands at EA.
- R6: When EA[1:0] is 0, one beat is sent with `mem_addr` = EA, `mem_be` = 4'b1111, and `mem_data` = the word.
- R7: When EA[1:0] = k is not 0, two beats are sent. The first has `mem_addr` = EA & ~3, `mem_be` = 4'b1111 >> k, and the word shifted right by 8k. The second has `mem_addr` + 4, the complementary enables, and the word shifted left by 32-8k.
- R8: While `mem_valid` is high and `mem_ready` is low, the beat payload holds steady. `iss_ready` is low whenever a beat is pending.
- R9: A matching word issued with `msr_fp` = 0 pulses `exc_fp_unavail` in its issue cycle, with no memory beat and no `pc_we`. If the word is also illegal, the illegal flag wins.
- R10: `pc_we` pulses exactly in the cycle the final beat is accepted, with `pc_next` = issued PC + 4.
- R11: `rsv_clear` pulses together with `pc_we` when three things hold: `rsv_track_en` and `rsv_active` are both high, and `rsv_addr[31:2]` equals the 4-byte granule of EA, or, for an unaligned EA, the next granule.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Unit idle, can take an instruction |
| iss_instr | input | 32 | Instruction word |
| iss_pc | input | ADDR_W | PC of the instruction |
| iss_gpr_a | input | XLEN | Base register read data |
| iss_gpr_b | input | XLEN | Index register read data |
| iss_fpr | input | FLEN | Source FP register bit pattern |
| msr_fp | input | 1 | FP unit enabled |
| rsv_track_en | input | 1 | Reservation tracking enabled |
| rsv_active | input | 1 | A reservation is held |
| rsv_addr | input | ADDR_W | Reserved address |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Word-aligned write address |
| mem_data | output | 32 | Write data, big-endian lanes |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| pc_we | output | 1 | PC update strobe |
| pc_next | output | ADDR_W | Next PC |
| rsv_clear | output | 1 | Invalidate the reservation |
| exc_fp_unavail | output | 1 | FP-unavailable exception |
| illegal_insn | output | 1 | Instruction not handled here |

## Verification
The assertions check the handshake on every cycle: the beat payload holds under back-pressure, issue stays closed during a store, and a split store always goes on to its second beat. They also check the timing of the pulses: the PC and reservation strobes occur only on an accepted final beat, and at most one of illegal, exception or write activity occurs at a time. Only the bench's sweeps can show the values themselves. These are the decode of each opcode bit, the zero-base rule, wrap-around of the address, the byte-lane split for each offset, and the granule comparison for the reservation.

// File: rtl/fpiw_pkg.sv
package fpiw_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam logic [5:0]  PRIM_OP = 6'd31;
  localparam logic [9:0]  EXT_OP  = 10'd983;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;

  typedef struct packed {
    logic hit;
    logic base_zero;
  } dec_t;
endpackage

// File: rtl/fpiw_decode.sv
module fpiw_decode
  import fpiw_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [5:0] prim;
  logic [9:0] ext;
  logic [4:0] base_f;

  assign prim   = instr[31:26];
  assign ext    = instr[10:1];
  assign base_f = instr[20:16];

  always_comb begin
    dec.hit       = (prim == PRIM_OP) && (ext == EXT_OP);
    dec.base_zero = (base_f == 5'd0);
  end
endmodule

// File: rtl/fpiw_agu.sv
module fpiw_agu #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              base_zero,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   index,
  output logic [ADDR_W-1:0] ea
);
  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] sum;

  assign base_sel = base_zero ? '0 : base;
  assign sum      = base_sel + index;
  assign ea       = sum[ADDR_W-1:0];
endmodule

// File: rtl/fpiw_lane.sv
module fpiw_lane
  import fpiw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        off,
  input  logic              hi,
  output logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  be
);
  logic [5:0] sh_lo;
  logic [5:0] sh_hi;

  assign sh_lo = {1'b0, off, 3'b000};
  assign sh_hi = 6'd32 - sh_lo;
  assign data  = hi ? (word << sh_hi) : (word >> sh_lo);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic first_word;
    assign first_word    = (2'(i) >= off);
    assign be[LANES-1-i] = hi ? !first_word : first_word;
  end
endmodule

// File: rtl/fpiw_rsv_match.sv
module fpiw_rsv_match #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              track_en,
  input  logic              active,
  input  logic [ADDR_W-1:0] rsv_addr,
  input  logic [ADDR_W-1:0] ea,
  input  logic              straddle,
  output logic              hit
);
  localparam int unsigned GW = ADDR_W - 2;
  logic [GW-1:0] g_first;
  logic [GW-1:0] g_next;
  logic [GW-1:0] g_rsv;

  assign g_first = ea[ADDR_W-1:2];
  assign g_next  = g_first + GW'(1);
  assign g_rsv   = rsv_addr[ADDR_W-1:2];
  assign hit     = track_en && active &&
                   ((g_rsv == g_first) || (straddle && (g_rsv == g_next)));
endmodule

// File: rtl/fpiw_store_unit.sv
module fpiw_store_unit
  import fpiw_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned FLEN   = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [31:0]       iss_instr,
  input  logic [ADDR_W-1:0] iss_pc,
  input  logic [XLEN-1:0]   iss_gpr_a,
  input  logic [XLEN-1:0]   iss_gpr_b,
  input  logic [FLEN-1:0]   iss_fpr,
  input  logic              msr_fp,
  input  logic              rsv_track_en,
  input  logic              rsv_active,
  input  logic [ADDR_W-1:0] rsv_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic [3:0]        mem_be,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_next,
  output logic              rsv_clear,
  output logic              exc_fp_unavail,
  output logic              illegal_insn
);
  localparam int unsigned GW = ADDR_W - 2;

  dec_t              dec;
  logic [ADDR_W-1:0] ea_d;
  st_e               st_q;
  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] word_q;
  logic              accept;
  logic              start;
  logic              hi_beat;
  logic              straddle;
  logic              last_beat;
  logic              rsv_hit;
  logic [GW-1:0]     beat_g;

  fpiw_decode u_dec (.instr(iss_instr), .dec(dec));

  fpiw_agu #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_agu (
    .base_zero(dec.base_zero), .base(iss_gpr_a), .index(iss_gpr_b), .ea(ea_d)
  );

  assign iss_ready      = (st_q == ST_IDLE);
  assign accept         = iss_valid && iss_ready;
  assign illegal_insn   = accept && !dec.hit;
  assign exc_fp_unavail = accept && dec.hit && !msr_fp;
  assign start          = accept && dec.hit && msr_fp;

  assign hi_beat   = (st_q == ST_HI);
  assign straddle  = (ea_q[1:0] != 2'b00);
  assign last_beat = hi_beat || !straddle;
  assign mem_valid = (st_q != ST_IDLE);
  assign beat_g    = ea_q[ADDR_W-1:2] + GW'(hi_beat);
  assign mem_addr  = {beat_g, 2'b00};

  fpiw_lane u_lane (
    .word(word_q), .off(ea_q[1:0]), .hi(hi_beat), .data(mem_data), .be(mem_be)
  );

  fpiw_rsv_match #(.ADDR_W(ADDR_W)) u_rsv (
    .track_en(rsv_track_en), .active(rsv_active), .rsv_addr(rsv_addr),
    .ea(ea_q), .straddle(straddle), .hit(rsv_hit)
  );

  assign pc_we     = mem_valid && mem_ready && last_beat;
  assign pc_next   = pc_q + ADDR_W'(4);
  assign rsv_clear = pc_we && rsv_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ea_q   <= '0;
      pc_q   <= '0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_LO;
          ea_q   <= ea_d;
          pc_q   <= iss_pc;
          word_q <= iss_fpr[WORD_W-1:0];
        end
        ST_LO: if (mem_ready) st_q <= last_beat ? ST_IDLE : ST_HI;
        ST_HI: if (mem_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpiw_store_chk.sv
module fpiw_store_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic [3:0]        mem_be,
  input logic              pc_we,
  input logic              rsv_clear,
  input logic              rsv_track_en,
  input logic              rsv_active,
  input logic              exc_fp_unavail,
  input logic              illegal_insn
);
  // R8
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_data) && $stable(mem_be)));
  // R8
  busy_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !iss_ready);
  // R6
  beat_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00 && mem_be != 4'b0000));
  // R7
  second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !pc_we) |=> mem_valid);
  // R10
  pc_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (mem_valid && mem_ready));
  // R11
  rsv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_clear |-> (pc_we && rsv_track_en && rsv_active));
  // R2
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_insn, exc_fp_unavail, mem_valid}));
endmodule

bind fpiw_store_unit fpiw_store_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_ready(iss_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_be(mem_be), .pc_we(pc_we), .rsv_clear(rsv_clear),
  .rsv_track_en(rsv_track_en), .rsv_active(rsv_active),
  .exc_fp_unavail(exc_fp_unavail), .illegal_insn(illegal_insn)
);

// File: tb/fpiw_store_unit_tb.sv
module fpiw_store_unit_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [31:0] iss_instr = '0;
  logic [31:0] iss_pc = '0;
  logic [63:0] iss_gpr_a = '0, iss_gpr_b = '0, iss_fpr = '0;
  logic        msr_fp = 1'b0, rsv_track_en = 1'b0, rsv_active = 1'b0;
  logic [31:0] rsv_addr = '0;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data, pc_next;
  logic [3:0]  mem_be;
  logic        pc_we, rsv_clear, exc_fp_unavail, illegal_insn;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fpiw_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_instr(iss_instr), .iss_pc(iss_pc), .iss_gpr_a(iss_gpr_a),
    .iss_gpr_b(iss_gpr_b), .iss_fpr(iss_fpr), .msr_fp(msr_fp),
    .rsv_track_en(rsv_track_en), .rsv_active(rsv_active), .rsv_addr(rsv_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .pc_we(pc_we), .pc_next(pc_next),
    .rsv_clear(rsv_clear), .exc_fp_unavail(exc_fp_unavail),
    .illegal_insn(illegal_insn)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] fs, input logic [4:0] ra,
                                     input logic [4:0] rb, input logic rc);
    return {6'd31, fs, ra, rb, 10'd983, rc};
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] f, input logic fp, input logic trk,
                       input logic act, input logic [31:0] raddr, input int stall);
    logic        hit;
    logic [63:0] base, sum;
    logic [31:0] ea, word, pc, dat;
    logic [1:0]  off;
    logic [3:0]  be;
    logic        rexp;
    int          nb;
    hit  = (ins[31:26] == 6'd31) && (ins[10:1] == 10'd983);
    base = (ins[20:16] == 5'd0) ? 64'd0 : a;
    sum  = base + b;
    ea   = sum[31:0];
    off  = ea[1:0];
    word = f[31:0];
    pc   = 32'h1000 + {ea[15:0], 4'h0};
    rexp = trk && act && ((raddr[31:2] == ea[31:2]) ||
           ((off != 2'd0) && (raddr[31:2] == ea[31:2] + 30'd1)));
    nb   = (off == 2'd0) ? 1 : 2;
    @(negedge clk);
    iss_valid = 1'b1; iss_instr = ins; iss_gpr_a = a; iss_gpr_b = b;
    iss_fpr = f; msr_fp = fp; iss_pc = pc;
    rsv_track_en = trk; rsv_active = act; rsv_addr = raddr;
    #1;
    chk("R8 iss_ready idle", iss_ready, 1);
    if (!hit) begin
      chk("R2 illegal flag", illegal_insn, 1);
      chk("R9 illegal wins over exc", exc_fp_unavail, 0);
      chk("R2 no pc_we", pc_we, 0);
      @(negedge clk); iss_valid = 1'b0; #1;
      chk("R2 no beat", mem_valid, 0);
      return;
    end
    chk("R1 match not illegal", illegal_insn, 0);
    if (!fp) begin
      chk("R9 exc flag", exc_fp_unavail, 1);
      @(negedge clk); iss_valid = 1'b0; #1;
      chk("R9 no beat", mem_valid, 0);
      chk("R9 no pc_we", pc_we, 0);
      return;
    end
    chk("R9 no exc when enabled", exc_fp_unavail, 0);
    @(negedge clk);
    iss_valid = 1'b0; iss_fpr = ~f; iss_gpr_a = ~a; iss_gpr_b = ~b; iss_pc = ~pc;
    for (int k = 0; k < nb; k++) begin
      logic [31:0] bad;
      bad = {ea[31:2], 2'b00} + (k == 1 ? 32'd4 : 32'd0);
      if (k == 0) begin
        dat = word >> (8 * off);
        be  = 4'hF >> off;
      end else begin
        dat = word << (32 - 8 * off);
        be  = ~(4'hF >> off);
      end
      for (int s = 0; s < stall; s++) begin
        mem_ready = 1'b0; #1;
        chk("R8 valid held", mem_valid, 1);
        chk("R8 addr held", mem_addr, bad);
        chk("R8 data held", mem_data, dat);
        chk("R8 busy", iss_ready, 0);
        chk("R10 no pc during stall", pc_we, 0);
        @(negedge clk);
      end
      mem_ready = 1'b1; #1;
      chk(nb == 1 ? "R6 addr" : "R7 addr", mem_addr, bad);
      chk(nb == 1 ? "R6 be" : "R7 be", mem_be, be);
      chk("R5 data lanes", mem_data, dat);
      if (k == nb - 1) begin
        chk("R10 pc_we", pc_we, 1);
        chk("R10 pc_next", pc_next, pc + 32'd4);
        chk("R11 rsv_clear", rsv_clear, rexp);
      end else begin
        chk("R7 first beat not final", pc_we, 0);
      end
      @(negedge clk);
      mem_ready = 1'b0;
    end
    #1;
    chk("R10 idle after store", mem_valid, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset no beat", mem_valid, 0);
    chk("R8 reset ready", iss_ready, 1);
    rst_n = 1'b1;

    // R4 R5 R6 R7 R3: offsets x base-zero x stall
    for (int o = 0; o < 4; o++)
      for (int z = 0; z < 2; z++)
        for (int s = 0; s < 3; s++)
          issue(mk(5'd7, z ? 5'd0 : 5'd3, 5'd9, 1'b0), 64'hDEAD_0000_0000_0100,
                64'h0000_0000_0000_2040 + 64'(o), 64'h89AB_CDEF_1234_5678 ^ 64'(o * 77),
                1'b1, 1'b0, 1'b0, 32'h0, s);

    // R4 wrap-around and upper-bit discard
    issue(mk(5'd1, 5'd2, 5'd3, 1'b0), 64'hFFFF_FFFF_FFFF_FFF0, 64'h22,
          64'h0000_0000_A1B2_C3D4, 1'b1, 1'b0, 1'b0, 32'h0, 1);
    issue(mk(5'd1, 5'd2, 5'd3, 1'b0), 64'h1234_5678_0000_0000, 64'h8,
          64'hFFFF_FFFF_0102_0304, 1'b1, 1'b0, 1'b0, 32'h0, 0);

    // R1 Rc bit ignored
    issue(mk(5'd4, 5'd5, 5'd6, 1'b1), 64'h300, 64'h4,
          64'h5555_AAAA, 1'b1, 1'b0, 1'b0, 32'h0, 0);

    // R1 R2: flip each opcode bit
    for (int k = 0; k < 10; k++)
      issue(mk(5'd1, 5'd1, 5'd1, 1'b0) ^ (32'd1 << (k + 1)), 64'h0, 64'h0,
            64'h0, 1'b1, 1'b0, 1'b0, 32'h0, 0);
    for (int k = 0; k < 6; k++)
      issue(mk(5'd1, 5'd1, 5'd1, 1'b0) ^ (32'd1 << (k + 26)), 64'h0, 64'h0,
            64'h0, (k % 2) == 0, 1'b0, 1'b0, 32'h0, 0);

    // R9 FP disabled
    issue(mk(5'd2, 5'd0, 5'd3, 1'b0), 64'h0, 64'h400, 64'h1, 1'b0, 1'b1, 1'b1, 32'h400, 0);

    // R11 reservation sweep
    for (int o = 0; o < 4; o++)
      for (int d = -1; d < 3; d++)
        for (int m = 0; m < 3; m++)
          issue(mk(5'd3, 5'd0, 5'd8, 1'b0), 64'h0, 64'h800 + 64'(o),
                64'hCAFE_F00D, 1'b1, m != 1, m != 2,
                32'h800 + 32'(d * 4) + 32'(o ^ 1), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule